// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

This block gives a processor a signed integer division unit that is driven entirely through word-wide register accesses. Software loads a dividend and a divisor, each held as a multi-word little-endian value, picks an operand-width mode in a control word, and reads back a quotient, a remainder and an error flag once the busy flag in the control word has cleared. Any write to the control word or to an operand word starts the division again from the current register contents, so software may write the operands in any order and simply poll for completion after the last write.

The engine is a sequential restoring divider that produces one quotient bit per clock on operand magnitudes and applies the signs at the end. Two corner cases are given fixed, defined results: a zero divisor, and the most negative dividend divided by minus one. Both complete in the same number of cycles as an ordinary division.

Top module: `sdivUnit`

## Requirements
- R1: After reset the control word reads 0 (not busy, no error, mode 0) and all quotient and remainder words read 0.
- R2: With a 32-bit bus and 64-bit operands the word map is: 0 control, 1 reserved (reads 0), 2-3 dividend, 4-5 divisor, 6-7 quotient, 8-9 remainder; each 64-bit value is little-endian, the lower address holding bits 31:0. The control word holds the mode in bits 1:0 (read back as written), the error flag in bit 14 and the busy flag in bit 15.
- R3: A write to the control word or to any dividend or divisor word sets busy on the next cycle; busy then reads 1 for exactly W+2 cycles (66 by default), after which the results are valid. A write while busy restarts the count and the division uses the newest operand values.
- R4: Mode 0 sign-extends the low 32 bits of both the dividend and the divisor; their upper words are ignored.
- R5: Modes 1 and 3 use the full 64-bit dividend and sign-extend the low 32 bits of the divisor.
- R6: Mode 2 uses full 64-bit dividend and divisor.
- R7: For a nonzero divisor outside the overflow case, the quotient truncates toward zero, the remainder is zero or has the sign of the dividend, and the error flag is cleared.
- R8: With a zero (mode-adjusted) divisor the error flag is set, the remainder equals the mode-adjusted dividend, and the quotient is 1 if that dividend is negative and 0 otherwise.
- R9: With dividend equal to the most negative 64-bit value and divisor -1, the error flag is set, the quotient equals the dividend, and the remainder keeps its previous value.
- R10: While busy, the quotient, remainder and error flag keep the values of the last completed division.
- R11: Writes to the quotient, remainder or reserved words change nothing and do not start a division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one word |
| wrAddr | input | 4 | Word index of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Word index of the read |
| rdData | output | 32 | Read data, combinational from rdAddr |

## Verification
On every cycle the assertions check that a start always raises busy and that busy never rises without one, that the result registers and the error flag move only on the completion strobe, that a zero divisor always leaves the flag set with the dividend in the remainder, that the overflow case never disturbs the remainder, and that an ordinary result has a remainder carrying the dividend's sign. Whether the quotient is numerically right for each mode, whether the upper words are really ignored by the sign-extending modes, the exact busy length and the restart on a mid-flight write can only be shown by the bench, which compares every division against its own reference model.

// File: rtl/sdivPkg.sv
package sdivPkg;
  typedef enum logic [1:0] {
    MODE_BOTH_NARROW = 2'd0,
    MODE_WIDE_NARROW = 2'd1,
    MODE_BOTH_WIDE   = 2'd2,
    MODE_WIDE_NARROW_ALT = 2'd3
  } divMode_e;

  typedef struct packed {
    logic load;
    logic step;
    logic commit;
  } divStrobe_t;
endpackage

// File: rtl/sdivCtrl.sv
module sdivCtrl
  import sdivPkg::*;
#(
  parameter int STEPS = 64,
  localparam int CNT_W = $clog2(STEPS + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output divStrobe_t strobes,
  output logic       busy
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_DONE} state_e;

  state_e state;
  logic [CNT_W-1:0] stepCnt;
  logic lastStep;

  assign lastStep = (stepCnt == CNT_W'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      busy    <= 1'b0;
    end else if (start) begin
      state   <= S_LOAD;
      stepCnt <= '0;
      busy    <= 1'b1;
    end else begin
      case (state)
        S_LOAD: state <= S_RUN;
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (lastStep) state <= S_DONE;
        end
        S_DONE: begin
          state <= S_IDLE;
          busy  <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load   = (state == S_LOAD) && !start;
    strobes.step   = (state == S_RUN)  && !start;
    strobes.commit = (state == S_DONE) && !start;
  end

  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy);
  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  assert_commit_in_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> busy);
  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= CNT_W'(STEPS));
  assert_commit_ends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !start) |=> !busy);
endmodule

// File: rtl/sdivDatapath.sv
module sdivDatapath
  import sdivPkg::*;
#(
  parameter int W = 64,
  parameter int BUS_W = 32,
  localparam int WORDS = W / BUS_W,
  localparam int ADDR_W = $clog2(5 * WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData,
  input  logic              busy,
  input  divStrobe_t        strobes,
  output logic              start
);
  localparam int HALF     = W / 2;
  localparam int NUM_BASE = WORDS;
  localparam int DEN_BASE = 2 * WORDS;
  localparam int QUO_BASE = 3 * WORDS;
  localparam int REM_BASE = 4 * WORDS;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] numReg, denReg, quotReg, remReg;
  logic [1:0]   modeReg;
  logic         errFlag;

  // operand latch and engine state
  logic [W-1:0] nAdj, dAdj, nLatch, dMag, qShift, remAcc;
  logic         qNeg, rNeg, zeroCase, ovfCase;
  logic [W:0]   rTmp, diff;

  assign start = wrEn && ((wrAddr == '0) ||
                 ((wrAddr >= ADDR_W'(NUM_BASE)) && (wrAddr < ADDR_W'(QUO_BASE))));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      numReg  <= '0;
      denReg  <= '0;
      modeReg <= 2'd0;
    end else if (wrEn) begin
      if (wrAddr == '0) modeReg <= wrData[1:0];
      for (int i = 0; i < WORDS; i++) begin
        if (wrAddr == ADDR_W'(NUM_BASE + i)) numReg[i*BUS_W +: BUS_W] <= wrData;
        if (wrAddr == ADDR_W'(DEN_BASE + i)) denReg[i*BUS_W +: BUS_W] <= wrData;
      end
    end
  end

  always_comb begin
    if (divMode_e'(modeReg) == MODE_BOTH_NARROW)
      nAdj = {{HALF{numReg[HALF-1]}}, numReg[HALF-1:0]};
    else
      nAdj = numReg;
    if (divMode_e'(modeReg) == MODE_BOTH_WIDE)
      dAdj = denReg;
    else
      dAdj = {{HALF{denReg[HALF-1]}}, denReg[HALF-1:0]};
  end

  assign rTmp = {remAcc, qShift[W-1]};
  assign diff = rTmp - {1'b0, dMag};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nLatch   <= '0;
      dMag     <= '0;
      qShift   <= '0;
      remAcc   <= '0;
      qNeg     <= 1'b0;
      rNeg     <= 1'b0;
      zeroCase <= 1'b0;
      ovfCase  <= 1'b0;
    end else if (strobes.load) begin
      nLatch   <= nAdj;
      dMag     <= dAdj[W-1] ? -dAdj : dAdj;
      qShift   <= nAdj[W-1] ? -nAdj : nAdj;
      remAcc   <= '0;
      qNeg     <= nAdj[W-1] ^ dAdj[W-1];
      rNeg     <= nAdj[W-1];
      zeroCase <= (dAdj == '0);
      ovfCase  <= (nAdj == MOST_NEG) && (dAdj == {W{1'b1}});
    end else if (strobes.step) begin
      if (!diff[W]) begin
        remAcc <= diff[W-1:0];
        qShift <= {qShift[W-2:0], 1'b1};
      end else begin
        remAcc <= rTmp[W-1:0];
        qShift <= {qShift[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotReg <= '0;
      remReg  <= '0;
      errFlag <= 1'b0;
    end else if (strobes.commit) begin
      if (zeroCase) begin
        quotReg <= nLatch[W-1] ? W'(1) : '0;
        remReg  <= nLatch;
        errFlag <= 1'b1;
      end else if (ovfCase) begin
        quotReg <= nLatch;
        errFlag <= 1'b1;
      end else begin
        quotReg <= qNeg ? -qShift : qShift;
        remReg  <= rNeg ? -remAcc : remAcc;
        errFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == '0) begin
      rdData[15]  = busy;
      rdData[14]  = errFlag;
      rdData[1:0] = modeReg;
    end
    for (int i = 0; i < WORDS; i++) begin
      if (rdAddr == ADDR_W'(NUM_BASE + i)) rdData = numReg[i*BUS_W +: BUS_W];
      if (rdAddr == ADDR_W'(DEN_BASE + i)) rdData = denReg[i*BUS_W +: BUS_W];
      if (rdAddr == ADDR_W'(QUO_BASE + i)) rdData = quotReg[i*BUS_W +: BUS_W];
      if (rdAddr == ADDR_W'(REM_BASE + i)) rdData = remReg[i*BUS_W +: BUS_W];
    end
  end

  assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(quotReg) && $stable(remReg) && $stable(errFlag)));
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && zeroCase) |=> (errFlag && remReg == $past(nLatch)));
  assert_ovf_keep_rem_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && ovfCase && !zeroCase) |=> (errFlag && $stable(remReg)));
  assert_rem_sign_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !zeroCase && !ovfCase) |=>
      (!errFlag && (remReg == '0 || remReg[W-1] == $past(rNeg))));
endmodule

// File: rtl/sdivUnit.sv
module sdivUnit
  import sdivPkg::*;
#(
  parameter int W = 64,
  parameter int BUS_W = 32,
  localparam int ADDR_W = $clog2(5 * (W / BUS_W))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData
);
  divStrobe_t strobes;
  logic busy;
  logic start;

  sdivCtrl #(.STEPS(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobes(strobes), .busy(busy)
  );

  sdivDatapath #(.W(W), .BUS_W(BUS_W)) u_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .strobes(strobes),
    .start(start)
  );
endmodule

// File: tb/test_sdivUnit.sv
module test_sdivUnit;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 66;
  localparam logic [63:0] MOST_NEG = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [63:0] modelQuot = '0;
  logic [63:0] modelRem = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdivUnit i_sdivUnit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic rd64(input logic [3:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    d = {hi, lo};
  endtask

  task automatic refDiv(input logic [1:0] mode, input logic [63:0] n, d, prevRem,
                        output logic [63:0] q, r, output logic e);
    logic signed [63:0] na, da;
    na = (mode == 2'd0) ? {{32{n[31]}}, n[31:0]} : n;
    da = (mode == 2'd2) ? d : {{32{d[31]}}, d[31:0]};
    if (da == 0) begin
      q = na[63] ? 64'd1 : 64'd0; r = na; e = 1'b1;
    end else if (na == MOST_NEG && da == -64'sd1) begin
      q = na; r = prevRem; e = 1'b1;
    end else begin
      q = na / da; r = na % da; e = 1'b0;
    end
  endtask

  task automatic waitDone(input string tag);
    logic [31:0] c;
    int cnt;
    cnt = 0;
    rd(4'd0, c);
    while (c[15] && cnt < 1000) begin
      cnt++;
      @(negedge clk);
      rd(4'd0, c);
    end
    chk(tag, "busy cycles", 64'(cnt), 64'(LAT));
  endtask

  task automatic collect(input string tag, input logic [1:0] mode,
                         input logic [63:0] n, d);
    logic [63:0] q, r, aq, ar;
    logic e;
    logic [31:0] c;
    refDiv(mode, n, d, modelRem, q, r, e);
    rd64(4'd6, aq);
    rd64(4'd8, ar);
    rd(4'd0, c);
    chk(tag, "quotient", aq, q);
    chk(tag, "remainder", ar, r);
    chk(tag, "error flag", 64'(c[14]), 64'(e));
    chk("R2", "mode readback", 64'(c[1:0]), 64'(mode));
    modelQuot = q;
    modelRem = r;
  endtask

  task automatic runDiv(input string tag, input logic [1:0] mode,
                        input logic [63:0] n, d);
    logic [63:0] held;
    wr(4'd2, n[31:0]);
    wr(4'd3, n[63:32]);
    wr(4'd4, d[31:0]);
    wr(4'd5, d[63:32]);
    wr(4'd0, {30'd0, mode});
    rd64(4'd6, held);
    chk("R10", "quotient held while busy", held, modelQuot);
    waitDone("R3");
    collect(tag, mode, n, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] v64;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    rd(4'd0, v);
    chk("R1", "control after reset", 64'(v), 64'd0);
    rd64(4'd6, v64);
    chk("R1", "quotient after reset", v64, 64'd0);
    rd64(4'd8, v64);
    chk("R1", "remainder after reset", v64, 64'd0);

    // R4 mode 0
    runDiv("R4", 2'd0, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE);
    runDiv("R4", 2'd0, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2);
    runDiv("R4", 2'd0, 64'hFFFF_FFFF_0000_0010, 64'h1234_5678_0000_0003);
    runDiv("R4", 2'd0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF);
    // R5 modes 1 and 3
    runDiv("R5", 2'd1, 64'h0123_4567_89AB_CDEF, 64'hAAAA_AAAA_FFFF_FFF0);
    runDiv("R5", 2'd3, 64'hF000_0000_0000_0001, 64'h5555_5555_0000_0007);
    // R6 mode 2
    runDiv("R6", 2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0000);
    runDiv("R6", 2'd2, MOST_NEG, 64'd3);
    // R7 sign rules
    runDiv("R7", 2'd2, 64'hFFFF_FFFF_FFFF_FFF3, 64'hFFFF_FFFF_FFFF_FFFB);
    runDiv("R7", 2'd2, 64'd13, 64'hFFFF_FFFF_FFFF_FFFB);
    // R8 zero divisor
    runDiv("R8", 2'd2, 64'hFFFF_FFFF_FFFF_FFFB, 64'd0);
    runDiv("R8", 2'd2, 64'd5, 64'd0);
    runDiv("R8", 2'd0, 64'h1111_1111_8000_0001, 64'hFFFF_FFFF_0000_0000);
    // R9 overflow: remainder kept from the previous division
    runDiv("R7", 2'd2, 64'd100, 64'd7);
    runDiv("R9", 2'd2, MOST_NEG, 64'hFFFF_FFFF_FFFF_FFFF);
    runDiv("R9", 2'd1, MOST_NEG, 64'h0000_0000_FFFF_FFFF);

    // R11 ignored writes
    wr(4'd6, 32'hDEAD_BEEF);
    wr(4'd9, 32'hCAFE_F00D);
    wr(4'd1, 32'h0000_8003);
    rd(4'd0, v);
    chk("R11", "no start from result writes", 64'(v[15]), 64'd0);
    rd64(4'd6, v64);
    chk("R11", "quotient unchanged", v64, modelQuot);
    rd64(4'd8, v64);
    chk("R11", "remainder unchanged", v64, modelRem);
    rd(4'd1, v);
    chk("R11", "reserved word reads 0", 64'(v), 64'd0);

    // R3 restart while busy
    wr(4'd2, 32'd1000);
    wr(4'd3, 32'd0);
    wr(4'd4, 32'd9);
    wr(4'd5, 32'd0);
    wr(4'd0, 32'd2);
    repeat (10) @(negedge clk);
    wr(4'd4, 32'd7);
    waitDone("R3");
    collect("R3", 2'd2, 64'd1000, 64'd7);

    // randomized
    for (int k = 0; k < 60; k++) begin
      logic [1:0] m;
      logic [63:0] n, d;
      string tag;
      m = 2'($urandom_range(0, 3));
      n = {$urandom, $urandom};
      d = {$urandom, $urandom};
      if (k % 4 == 1) d = {{48{d[15]}}, d[15:0]};
      if (k % 7 == 3) d = {$urandom, 32'd0};
      case (m)
        2'd0: tag = "R4";
        2'd2: tag = "R6";
        default: tag = "R5";
      endcase
      runDiv(tag, m, n, d);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule